// File: doc/BRIEF.md
# Address-Encoded Command Unlock Decoder

This block watches read strobes on a cartridge flash-space bus and separates ordinary memory reads from hidden controller commands. Every access is read as a pair: an 8-bit command address on the upper address byte and a 16-bit data value on the lower sixteen address bits. No data pins are involved. A command therefore travels entirely inside the address of a read cycle.

The decoder only accepts a command after a fixed five-access unlock pattern. A single stray access aborts the pattern. Once unlocked, exactly one following access is taken as a command. That access loads one of six 16-bit registers or the three option flags. Every other access is forwarded unchanged to the memory side. Each register is exposed as a parallel output for the rest of the cartridge logic.

Top module: `cmd_unlock_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, every register output and option flag is zero, `ext_addr_en` is low and no unlock progress is held.
- R2: For each strobed access, the command address is `bus_addr[23:16]` and the data value is `bus_addr[15:0]`.
- R3: The decoder arms only after five consecutive strobed accesses whose (command, data) values are, in order, (0xFF,0xD200), (0x00,0x1500), (0x01,0xD200), (0x02,0x1500) and (0xFE,0x1500).
- R4: An access that does not match the next expected unlock step drops all progress. The exception is an access matching the first step, which counts as step one, so that the next expected access is step two.
- R5: Exactly one access is taken as a command after a completed unlock. The access after it is an ordinary read, and another command needs a full new unlock.
- R6: Command 0x37 loads `ctrl_main`, 0xEE loads `ctrl_aux` and 0xDA loads `io_status` with the data value. The new value is visible from the cycle after the command access.
- R7: Command 0xC4 loads `game_bank`, 0xE0 loads `sram_bank` and 0x90 loads `id_mode` with the data value. The new value is visible from the cycle after the command access.
- R8: Command 0xE2 decodes its data value as follows. 0x1500 and 0xD200 set and clear `psram_wr_en`. 0xDD00 and 0x3900 set and clear `wide_wr_en`. 0x7E00 and 0x9400 set and clear `wide_rd_en`. Any other data value changes no flag.
- R9: A command access carrying any other command address changes no register or flag, and the decoder returns to idle.
- R10: `ext_addr_en` is high exactly while `ctrl_aux` holds 0x0630.
- R11: Each strobed access that is not taken as a command raises `mem_rd` in the same cycle and presents `mem_addr` equal to `bus_addr`. This includes the unlock accesses. The command access itself keeps `mem_rd` low.
- R12: Cycles without `rd_strobe` change no register, no flag and no unlock progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_strobe | input | 1 | One-cycle qualifier of a flash-space read access |
| bus_addr | input | 24 | Flash-space address of the access |
| mem_rd | output | 1 | Read forwarded to the flash device |
| mem_addr | output | 24 | Address forwarded to the flash device |
| ctrl_main | output | 16 | Main control word |
| ctrl_aux | output | 16 | Second control word |
| io_status | output | 16 | I/O status word |
| game_bank | output | 16 | Game-flash bank |
| sram_bank | output | 16 | Sram bank |
| id_mode | output | 16 | ID-mode word |
| psram_wr_en | output | 1 | Psram write enable flag |
| wide_wr_en | output | 1 | Wide sram write enable flag |
| wide_rd_en | output | 1 | Wide sram read enable flag |
| ext_addr_en | output | 1 | Extended flash address lines enabled |

## Verification
The assertions check three rules on every cycle. A register or flag changes only in the cycle after an armed access carrying its own command address. Arming happens only right after the final unlock step, and disarming follows every armed access. Idle cycles leave all state untouched.

Some behaviours can only be shown by the bench's scenarios. The bench sweeps all 256 command addresses and the full option-code set. It also covers an abort at every unlock step, both restart paths through the first step, and the pass-through of unlock and post-command accesses.

// File: rtl/cud_pkg.sv
package cud_pkg;
  localparam int CMD_W    = 8;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = CMD_W + DATA_W;
  localparam int N_UNLOCK = 5;
  localparam int N_WORDS  = 6;
  localparam int N_FLAGS  = 3;

  localparam logic [CMD_W-1:0] CMD_OPTIONS = 8'hE2;
  localparam logic [DATA_W-1:0] EXT_KEY    = 16'h0630;

  // word register command codes, index order = output order
  localparam logic [CMD_W-1:0] WORD_CODE [N_WORDS] =
    '{8'h37, 8'hEE, 8'hDA, 8'hC4, 8'hE0, 8'h90};

  // option flag set / clear data codes
  localparam logic [DATA_W-1:0] FLAG_SET [N_FLAGS] = '{16'h1500, 16'hDD00, 16'h7E00};
  localparam logic [DATA_W-1:0] FLAG_CLR [N_FLAGS] = '{16'hD200, 16'h3900, 16'h9400};

  function automatic logic [ADDR_W-1:0] unlock_step(input int idx);
    logic [ADDR_W-1:0] v;
    case (idx)
      0:       v = {8'hFF, 16'hD200};
      1:       v = {8'h00, 16'h1500};
      2:       v = {8'h01, 16'hD200};
      3:       v = {8'h02, 16'h1500};
      default: v = {8'hFE, 16'h1500};
    endcase
    return v;
  endfunction
endpackage

// File: rtl/cud_rst_sync.sv
module cud_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cud_unlock_seq.sv
module cud_unlock_seq
  import cud_pkg::*;
#(
  parameter int STEPS = N_UNLOCK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic [ADDR_W-1:0] acc_word,
  output logic              armed,
  output logic              cmd_fire
);
  localparam int SW = $clog2(STEPS + 1);

  logic [SW-1:0] step_q, step_d;
  logic          hit_next, hit_first;

  assign armed     = (step_q == SW'(STEPS));
  assign cmd_fire  = acc_vld && armed;
  assign hit_first = (acc_word == unlock_step(0));

  always_comb begin
    hit_next = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      if (step_q == SW'(i) && acc_word == unlock_step(i)) hit_next = 1'b1;
    end
  end

  always_comb begin
    step_d = step_q;
    if (acc_vld) begin
      if (armed)          step_d = '0;
      else if (hit_next)  step_d = step_q + 1'b1;
      else if (hit_first) step_d = SW'(1);
      else                step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (acc_vld) step_q <= step_d;
  end
endmodule

// File: rtl/cud_cmd_regs.sv
module cud_cmd_regs
  import cud_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fire,
  input  logic [CMD_W-1:0]                cmd,
  input  logic [DATA_W-1:0]               data,
  output logic [N_WORDS-1:0][DATA_W-1:0]  words,
  output logic [N_FLAGS-1:0]              flags
);
  genvar gi;

  generate
    for (gi = 0; gi < N_WORDS; gi++) begin : g_word
      logic [DATA_W-1:0] q;
      logic              en;
      assign en = fire && (cmd == WORD_CODE[gi]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= data;
      end
      assign words[gi] = q;
    end

    for (gi = 0; gi < N_FLAGS; gi++) begin : g_flag
      logic q, d, en;
      assign en = fire && (cmd == CMD_OPTIONS) &&
                  (data == FLAG_SET[gi] || data == FLAG_CLR[gi]);
      assign d  = (data == FLAG_SET[gi]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (en) q <= d;
      end
      assign flags[gi] = q;
    end
  endgenerate
endmodule

// File: rtl/cmd_unlock_decoder.sv
module cmd_unlock_decoder
  import cud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_strobe,
  input  logic [23:0]       bus_addr,
  output logic              mem_rd,
  output logic [23:0]       mem_addr,
  output logic [15:0]       ctrl_main,
  output logic [15:0]       ctrl_aux,
  output logic [15:0]       io_status,
  output logic [15:0]       game_bank,
  output logic [15:0]       sram_bank,
  output logic [15:0]       id_mode,
  output logic              psram_wr_en,
  output logic              wide_wr_en,
  output logic              wide_rd_en,
  output logic              ext_addr_en
);
  logic                           rst_n_int;
  logic                           armed, cmd_fire;
  logic [N_WORDS-1:0][DATA_W-1:0] words;
  logic [N_FLAGS-1:0]             flags;

  cud_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  cud_unlock_seq u_seq (
    .clk(clk), .rst_n(rst_n_int), .acc_vld(rd_strobe),
    .acc_word(bus_addr), .armed(armed), .cmd_fire(cmd_fire)
  );

  cud_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n_int), .fire(cmd_fire),
    .cmd(bus_addr[ADDR_W-1:DATA_W]), .data(bus_addr[DATA_W-1:0]),
    .words(words), .flags(flags)
  );

  assign mem_rd      = rd_strobe && !armed;
  assign mem_addr    = bus_addr;
  assign ctrl_main   = words[0];
  assign ctrl_aux    = words[1];
  assign io_status   = words[2];
  assign game_bank   = words[3];
  assign sram_bank   = words[4];
  assign id_mode     = words[5];
  assign psram_wr_en = flags[0];
  assign wide_wr_en  = flags[1];
  assign wide_rd_en  = flags[2];
  assign ext_addr_en = (ctrl_aux == EXT_KEY);
endmodule

// File: rtl/cud_checker.sv
module cud_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_strobe,
  input logic [23:0] bus_addr,
  input logic        armed,
  input logic [15:0] ctrl_main,
  input logic [15:0] game_bank,
  input logic [15:0] id_mode,
  input logic [2:0]  opt_flags
);
  AST_CTRL_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_main) |-> $past(armed && rd_strobe && bus_addr[23:16] == 8'h37)); // R6
  AST_BANK_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(game_bank) |-> $past(armed && rd_strobe && bus_addr[23:16] == 8'hC4)); // R7
  AST_OPT_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(opt_flags) |-> $past(armed && rd_strobe && bus_addr[23:16] == 8'hE2)); // R8
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    armed && rd_strobe |=> !armed); // R5
  AST_ARM_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(rd_strobe && bus_addr == 24'hFE1500)); // R3
  AST_QUIET_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(ctrl_main) && $stable(id_mode) && $stable(opt_flags) && $stable(armed)); // R12
endmodule

bind cmd_unlock_decoder cud_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .bus_addr(bus_addr),
  .armed(armed), .ctrl_main(ctrl_main), .game_bank(game_bank),
  .id_mode(id_mode), .opt_flags({wide_rd_en, wide_wr_en, psram_wr_en})
);

// File: tb/cmd_unlock_decoder_tb.sv
module cmd_unlock_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_strobe;
  logic [23:0] bus_addr;
  logic        mem_rd;
  logic [23:0] mem_addr;
  logic [15:0] ctrl_main, ctrl_aux, io_status, game_bank, sram_bank, id_mode;
  logic        psram_wr_en, wide_wr_en, wide_rd_en, ext_addr_en;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] e_w [6];
  logic [2:0]  e_f;

  always #5 clk = ~clk;

  cmd_unlock_decoder u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " ctrl_main"}, ctrl_main, e_w[0]);
    chk({req, " ctrl_aux"},  ctrl_aux,  e_w[1]);
    chk({req, " io_status"}, io_status, e_w[2]);
    chk({req, " game_bank"}, game_bank, e_w[3]);
    chk({req, " sram_bank"}, sram_bank, e_w[4]);
    chk({req, " id_mode"},   id_mode,   e_w[5]);
    chk({req, " flags"}, {wide_rd_en, wide_wr_en, psram_wr_en}, e_f);
    chk("R10 ext_addr_en", ext_addr_en, e_w[1] == 16'h0630);
  endtask

  // one strobed access; checks pass-through in the access cycle
  task automatic access(input logic [23:0] a, input logic exp_pass, input string req);
    @(negedge clk);
    rd_strobe = 1'b1;
    bus_addr  = a;
    #1;
    chk({req, " mem_rd"}, mem_rd, exp_pass);
    if (exp_pass) chk("R11 mem_addr", mem_addr, a);
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  function automatic logic [23:0] ustep(input int i);
    case (i)
      0: return 24'hFFD200;
      1: return 24'h001500;
      2: return 24'h01D200;
      3: return 24'h021500;
      default: return 24'hFE1500;
    endcase
  endfunction

  task automatic unlock();
    for (int i = 0; i < 5; i++) access(ustep(i), 1'b1, "R11 unlock pass");
  endtask

  // expected effect of a command accepted per R6..R9
  task automatic model_cmd(input logic [7:0] c, input logic [15:0] d);
    case (c)
      8'h37: e_w[0] = d;
      8'hEE: e_w[1] = d;
      8'hDA: e_w[2] = d;
      8'hC4: e_w[3] = d;
      8'hE0: e_w[4] = d;
      8'h90: e_w[5] = d;
      8'hE2: case (d)
        16'h1500: e_f[0] = 1'b1;
        16'hD200: e_f[0] = 1'b0;
        16'hDD00: e_f[1] = 1'b1;
        16'h3900: e_f[1] = 1'b0;
        16'h7E00: e_f[2] = 1'b1;
        16'h9400: e_f[2] = 1'b0;
        default: ;
      endcase
      default: ;
    endcase
  endtask

  task automatic do_cmd(input logic [7:0] c, input logic [15:0] d, input string req);
    unlock();
    access({c, d}, 1'b0, "R11 cmd suppressed");
    model_cmd(c, d);
    check_all(req);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) e_w[i] = '0;
    e_f = '0;
    rst_n = 1'b0; rd_strobe = 1'b0; bus_addr = '0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after reset");

    // sweep every command address (R2, R6, R7, R9), then an unlocked retry (R5)
    for (int c = 0; c < 256; c++) begin
      logic [15:0] d;
      d = {8'(c) ^ 8'h5A, 8'(c)};
      do_cmd(8'(c), d, "R6/R7/R9 sweep");
      access({8'h37, 16'hBEEF}, 1'b1, "R5 no second cmd");
      check_all("R5 second access ignored");
    end

    // options codes plus a non-code (R8)
    do_cmd(8'hE2, 16'h1500, "R8 psram on");
    do_cmd(8'hE2, 16'hDD00, "R8 wide wr on");
    do_cmd(8'hE2, 16'h7E00, "R8 wide rd on");
    do_cmd(8'hE2, 16'h1234, "R8 non-code");
    do_cmd(8'hE2, 16'hD200, "R8 psram off");
    do_cmd(8'hE2, 16'h3900, "R8 wide wr off");
    do_cmd(8'hE2, 16'h9400, "R8 wide rd off");

    // extended address key (R10)
    do_cmd(8'hEE, 16'h0630, "R10 key");
    chk("R10 ext on", ext_addr_en, 1'b1);
    do_cmd(8'hEE, 16'h0631, "R10 near key");
    chk("R10 ext off", ext_addr_en, 1'b0);

    // abort at every step: wrong access, then remaining steps, then a would-be command (R4)
    for (int k = 0; k < 5; k++) begin
      for (int j = 0; j < k; j++) access(ustep(j), 1'b1, "R4 partial");
      access({8'h37, 16'h1234}, 1'b1, "R4 stray");
      for (int j = k + 1; j < 5; j++) access(ustep(j), 1'b1, "R4 tail");
      access({8'h37, 16'hA5A5}, 1'b1, "R4 not armed");
      check_all("R4 abort");
    end

    // restart through the first step (R4, R3)
    access(ustep(0), 1'b1, "R4 restart");
    unlock();
    access({8'h90, 16'h3500}, 1'b0, "R4 restart cmd");
    model_cmd(8'h90, 16'h3500);
    check_all("R4 double first step");
    access(ustep(0), 1'b1, "R4 mid");
    access(ustep(1), 1'b1, "R4 mid");
    unlock();
    access({8'hC4, 16'h0077}, 1'b0, "R4 mid cmd");
    model_cmd(8'hC4, 16'h0077);
    check_all("R4 restart mid sequence");

    // idle cycles between steps must not disturb progress or state (R12)
    for (int i = 0; i < 5; i++) begin
      access(ustep(i), 1'b1, "R12 step");
      bus_addr = 24'h37FFFF;
      repeat (3) @(negedge clk);
    end
    check_all("R12 idle");
    access({8'hDA, 16'hC0DE}, 1'b0, "R12 cmd after gaps");
    model_cmd(8'hDA, 16'hC0DE);
    check_all("R12 progress kept");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule